// File: doc/BRIEF.md
# Free-Running Timer with Compare-Clear

This block is a 16-bit up-counter that runs from a prescaled count enable. A 3-bit field picks the division ratio. When the count equals a 16-bit compare-clear value, the counter wraps to zero and a sticky status flag is set. An interrupt line follows that flag when the interrupt enable is on. Software can zero the counter at once with a command bit.

A mode bit picks one of two external request sources for an automatic reset:
- a write-timing strobe;
- a position-detect pulse.

A reset request is held pending and is applied only at the next count tick. The current count and a run status are exported to attached output-compare logic.

Access is through a small synchronous register bus with a 1-bit address. Address 0 is the 8-bit control register, on the low byte. Address 1 is the compare-clear value. Read data is registered and appears one cycle after the read strobe.

Top module: `fr_timer`

## Requirements
- R1: After reset the count, the compare value and every control bit are 0. `run_o` and `irq_o` are low.
- R2: With counting enabled, `count_o` advances once every 2^S clocks, where S is control bits [2:0] (S=0 counts every clock, S=7 every 128). A new S applies at once.
- R3: A control write with bit 7 set makes the count 0 on the next clock edge, whether or not counting is enabled. Writing bit 7 as 0 leaves the count untouched. Bit 7 always reads 0.
- R4: On a count tick where the count equals the compare value, the next count is 0 rather than value+1, and the flag in control bit 5 is set.
- R5: A control write with bit 5 = 0 clears the flag, and bit 5 = 1 leaves it unchanged. If a compare match coincides with the clearing write, the flag ends up set.
- R6: `irq_o` is high exactly while control bit 4 and the flag are both 1.
- R7: Control bit 3 enables counting. While it is 0 the count holds. `run_o` shows bit 3.
- R8: Control bit 6 picks the reset request source: 0 takes `wr_timing`, 1 takes `pos_detect`. The input that is not selected has no effect on the count.
- R9: A reset request does not change the count at once. It is held until the next count tick, and that tick loads 0 instead of incrementing.
- R10: A control-register read with `bus_rmw` high returns bit 5 as 1 whatever the flag holds.
- R11: Read data appears on `bus_rdata` one cycle after `bus_rd`. Address 1 returns the compare value. Address 0 returns the control fields in bits [6:0], with zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_rmw | input | 1 | Marks a read as part of a read-modify-write |
| bus_addr | input | 1 | 0 = control register, 1 = compare-clear value |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| wr_timing | input | 1 | Write-timing reset request |
| pos_detect | input | 1 | Position-detect reset request |
| count_o | output | 16 | Current count |
| run_o | output | 1 | Counting enabled |
| irq_o | output | 1 | Compare-clear interrupt |

## Verification
Results fall due at different points:
- Register writes, the clear command and the interrupt change show one clock edge after the write. The bench samples them 1 ns after that edge, before any later tick can arrive.
- Read data falls due one edge after the read strobe. Each read pushes its expected value into a queue, and a monitor pops and compares at the next falling edge.
- Count progress depends on the prescaler phase, which the bench does not know. The bench therefore waits for `count_o` to change and measures the gap in cycles.
- Deferred resets are judged by two observations: the count stays frozen between the request and the next change, and it reads 0 at that change.

// File: rtl/fr_timer_pkg.sv
package fr_timer_pkg;
  localparam int SEL_W    = 3;
  localparam int BIT_CLR  = 7;
  localparam int BIT_MODE = 6;
  localparam int BIT_FLAG = 5;
  localparam int BIT_IE   = 4;
  localparam int BIT_EN   = 3;

  typedef struct packed {
    logic             mode;
    logic             flag;
    logic             ie;
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/fr_prescale.sv
module fr_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] pre_q, pre_d, mask;

  always_comb begin
    pre_d = pre_q + 1'b1;
    for (int i = 0; i < PW; i++) mask[i] = (i < int'(sel));
    tick = &(pre_q | ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/fr_count.sv
module fr_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen,
  input  logic          sw_clr,
  input  logic          rst_req,
  input  logic [CW-1:0] cmp,
  output logic [CW-1:0] cnt,
  output logic          match_hit,
  output logic          pend
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          eq;

  always_comb begin
    eq     = (cnt_q == cmp);
    cnt_d  = cnt_q;
    pend_d = pend_q | rst_req;
    if (sw_clr) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (cen) begin
      pend_d = 1'b0;
      if (pend_q || rst_req || eq) cnt_d = '0;
      else                         cnt_d = cnt_q + 1'b1;
    end
    match_hit = cen & ~sw_clr & eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign cnt  = cnt_q;
  assign pend = pend_q;
endmodule

// File: rtl/fr_regs.sv
module fr_regs
  import fr_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_rmw,
  input  logic          bus_addr,
  input  logic [CW-1:0] bus_wdata,
  input  logic          match_hit,
  output ctl_t          ctl,
  output logic [CW-1:0] cmp,
  output logic          sw_clr,
  output logic [CW-1:0] rdata
);
  ctl_t          ctl_q, ctl_d;
  logic [CW-1:0] cmp_q, cmp_d, rd_q, rd_d;
  logic          wr_ctl;

  always_comb begin
    wr_ctl = bus_wr & ~bus_addr;
    sw_clr = wr_ctl & bus_wdata[BIT_CLR];
    ctl_d  = ctl_q;
    cmp_d  = cmp_q;
    rd_d   = rd_q;
    if (wr_ctl) begin
      ctl_d.mode = bus_wdata[BIT_MODE];
      ctl_d.ie   = bus_wdata[BIT_IE];
      ctl_d.en   = bus_wdata[BIT_EN];
      ctl_d.sel  = bus_wdata[SEL_W-1:0];
      ctl_d.flag = ctl_q.flag & bus_wdata[BIT_FLAG];
    end
    if (match_hit) ctl_d.flag = 1'b1;
    if (bus_wr && bus_addr) cmp_d = bus_wdata;
    if (bus_rd) begin
      if (bus_addr) rd_d = cmp_q;
      else rd_d = {{(CW-8){1'b0}}, 1'b0, ctl_q.mode, ctl_q.flag | bus_rmw,
                   ctl_q.ie, ctl_q.en, ctl_q.sel};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '0;
      rd_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      cmp_q <= cmp_d;
      rd_q  <= rd_d;
    end
  end

  assign ctl   = ctl_q;
  assign cmp   = cmp_q;
  assign rdata = rd_q;
endmodule

// File: rtl/fr_timer.sv
module fr_timer
  import fr_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_rmw,
  input  logic          bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          wr_timing,
  input  logic          pos_detect,
  output logic [CW-1:0] count_o,
  output logic          run_o,
  output logic          irq_o
);
  logic [1:0]    rs_q;
  logic          rst_s;
  ctl_t          ctl;
  logic [CW-1:0] cmp_val;
  logic          tick, cen, sw_clr, match_hit, pend, rst_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  fr_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_s), .sel(ctl.sel), .tick(tick)
  );

  fr_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_s), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .match_hit(match_hit), .ctl(ctl), .cmp(cmp_val), .sw_clr(sw_clr),
    .rdata(bus_rdata)
  );

  always_comb begin
    cen     = ctl.en & tick;
    rst_req = ctl.mode ? pos_detect : wr_timing;
  end

  fr_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_s), .cen(cen), .sw_clr(sw_clr), .rst_req(rst_req),
    .cmp(cmp_val), .cnt(count_o), .match_hit(match_hit), .pend(pend)
  );

  assign run_o = ctl.en;
  assign irq_o = ctl.ie & ctl.flag;
endmodule

// File: rtl/fr_timer_chk.sv
module fr_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_rmw,
  input logic          bus_addr,
  input logic [CW-1:0] bus_wdata,
  input logic [CW-1:0] bus_rdata,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] cmp,
  input logic          run_o,
  input logic          tick,
  input logic          flag,
  input logic          pend
);
  logic clr_cmd;
  assign clr_cmd = bus_wr & ~bus_addr & bus_wdata[7];

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> count_o == '0);
  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && tick && !clr_cmd && count_o == cmp) |=> (count_o == '0 && flag));
  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !clr_cmd) |=> $stable(count_o));
  a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_cmd) |=> $stable(count_o));
  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !tick && !clr_cmd) |=> pend);
  a_r10_rmw_flag_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr && bus_rmw) |=> bus_rdata[5]);
  a_r11_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr) |=> !bus_rdata[7]);
endmodule

bind fr_timer fr_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_s), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .count_o(count_o), .cmp(cmp_val), .run_o(run_o),
  .tick(tick), .flag(ctl.flag), .pend(pend)
);

// File: tb/fr_timer_test.sv
module fr_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd, bus_rmw, bus_addr;
  logic [15:0] bus_wdata, bus_rdata, count_o;
  logic        wr_timing, pos_detect, run_o, irq_o;

  always #5 clk = ~clk;

  fr_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wr_timing(wr_timing), .pos_detect(pos_detect),
    .count_o(count_o), .run_o(run_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [15:0] exp;
    logic [15:0] mask;
    string       tag;
  } rd_item_t;

  rd_item_t q[$];
  int   total = 0;
  int   bad   = 0;
  logic rd_due;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data one cycle after each read
  always @(posedge clk) rd_due <= bus_rd;
  always @(negedge clk) begin
    if (rd_due === 1'b1) begin
      if (q.size() == 0) chk(1'b0, "read with no expected item", bus_rdata, 16'h0);
      else begin
        rd_item_t it;
        it = q.pop_front();
        chk((bus_rdata & it.mask) == (it.exp & it.mask), it.tag,
            bus_rdata & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic rmw, input logic [15:0] exp,
                    input logic [15:0] mask, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_rmw = rmw; bus_addr = a;
    it.exp = exp; it.mask = mask; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_rmw = 1'b0;
  endtask

  task automatic pulse(input bit which_pos);
    @(negedge clk);
    if (which_pos) pos_detect = 1'b1; else wr_timing = 1'b1;
    @(posedge clk); #1;
    pos_detect = 1'b0; wr_timing = 1'b0;
  endtask

  task automatic wait_change(output int gap);
    logic [15:0] v;
    v = count_o;
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (count_o == v && gap < 400);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g;
    logic [15:0] v;
    bit ok;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_rmw = 0; bus_addr = 0;
    bus_wdata = '0; wr_timing = 0; pos_detect = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(count_o == 0, "R1 count", count_o, 16'h0);
    chk(run_o == 0 && irq_o == 0, "R1 run/irq", {run_o, irq_o}, 16'h0);
    rd(1'b0, 1'b0, 16'h0000, 16'hffff, "R1 control reads 0");
    rd(1'b1, 1'b0, 16'h0000, 16'hffff, "R1 compare reads 0");

    // R11 compare readback
    wr(1'b1, 16'h0005);
    rd(1'b1, 1'b0, 16'h0005, 16'hffff, "R11 compare readback");

    // R2 divide by 1, R4 wrap at compare
    wr(1'b0, 16'h0008);
    chk(run_o == 1, "R7 run_o follows enable", run_o, 16'h1);
    wait_change(g); wait_change(g);
    chk(g == 1, "R2 sel0 gap", g[15:0], 16'd1);
    g = 0;
    while (count_o != 5 && g < 50) begin @(negedge clk); g++; end
    @(negedge clk);
    chk(count_o == 0, "R4 wrap to 0 after compare", count_o, 16'h0);
    rd(1'b0, 1'b0, 16'h0020, 16'h0020, "R4 flag set");
    chk(irq_o == 0, "R6 irq low with ie 0", irq_o, 16'h0);
    wr(1'b0, 16'h0038);
    chk(irq_o == 1, "R6 irq high with ie and flag", irq_o, 16'h1);

    // R7 stop
    wr(1'b0, 16'h0030);
    v = count_o;
    repeat (8) @(negedge clk);
    chk(count_o == v && run_o == 0, "R7 count holds while disabled", count_o, v);
    rd(1'b0, 1'b0, 16'h0020, 16'h0020, "R5 write 1 keeps flag");
    wr(1'b0, 16'h0010);
    chk(irq_o == 0, "R6 irq low after flag clear", irq_o, 16'h0);
    rd(1'b0, 1'b0, 16'h0010, 16'h00ff, "R5 flag cleared by 0");
    rd(1'b0, 1'b1, 16'h0030, 16'h00ff, "R10 rmw reads flag 1");
    rd(1'b0, 1'b0, 16'h0010, 16'h00ff, "R10 plain read after rmw");

    // R3 clear command, divide by 128
    wr(1'b1, 16'hffff);
    wr(1'b0, 16'h000f);
    wait_change(g); wait_change(g);
    chk(g == 128, "R2 sel7 gap", g[15:0], 16'd128);
    wr(1'b0, 16'h008f);
    chk(count_o == 0, "R3 clear command zeroes count", count_o, 16'h0);
    rd(1'b0, 1'b0, 16'h000f, 16'h00ff, "R3 bit7 reads 0");
    wait_change(g);
    v = count_o;
    wr(1'b0, 16'h000f);
    chk(count_o == v, "R3 bit7=0 no effect", count_o, v);

    // R9 deferred reset, mode 0
    wait_change(g);
    v = count_o;
    pulse(1'b0);
    ok = 1'b1;
    repeat (20) begin @(negedge clk); if (count_o != v) ok = 1'b0; end
    chk(ok, "R9 count unchanged until tick", count_o, v);
    wait_change(g);
    chk(count_o == 0, "R9 reset applied at tick", count_o, 16'h0);
    pulse(1'b1);
    wait_change(g);
    chk(count_o == 1, "R8 pos_detect ignored in mode 0", count_o, 16'h1);

    // R8 mode 1
    wr(1'b0, 16'h004f);
    wait_change(g);
    v = count_o;
    pulse(1'b0);
    wait_change(g);
    chk(count_o == v + 1, "R8 wr_timing ignored in mode 1", count_o, v + 16'h1);
    pulse(1'b1);
    wait_change(g);
    chk(count_o == 0, "R8 pos_detect resets in mode 1", count_o, 16'h0);

    // R5 match wins over same-cycle clear
    wr(1'b1, 16'h0003);
    wr(1'b0, 16'h0088);
    g = 0;
    @(negedge clk);
    while (count_o != 3 && g < 50) begin @(negedge clk); g++; end
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 16'h0008;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    wr(1'b0, 16'h0020);
    rd(1'b0, 1'b0, 16'h0020, 16'h0020, "R5 match beats clear");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11 all reads answered", q.size(), 16'h0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule